// File: doc/BRIEF.md
# Capture Input Deglitcher

This block cleans up an asynchronous capture pin before it reaches a timer's input-capture logic. The pin is first brought into the system clock domain by a two-flop synchronizer. The synchronized level is then sampled on single-cycle strobes. Three consecutive samples must agree before the filtered output moves to that level; a mixed set of samples leaves the output where it was.

A 2-bit select picks the sampling rate. It can be every system clock, one of two divided rates from a free-running prescaler, or the timer's own count-clock strobe. An enable input switches the output between the filtered level and the plain synchronized pin. The switch is a direct multiplexer, so toggling the enable can itself produce an edge that downstream logic sees. A settle flag reports when two sampling strobes have occurred since the select last changed. Only from that point is the filtered level meaningful.

All pins are plain control and status signals. There is no data stream here, so there is no valid/ready handshake and no back-pressure.

Top module: `capture_deglitch`

## Requirements
- R1: With `filt_en_i` = 0, `cap_o` equals the value `pin_i` had two system-clock edges earlier (two-flop synchronizer latency).
- R2: With `samp_sel_i` = 2'b00, a sample is taken on every clock. `cap_o` (filter on) takes a new level three clocks after the synchronized pin settles there, plus one clock for the output register.
- R3: `samp_sel_i` = 2'b01 samples once every 8 clocks and 2'b10 once every 32 clocks. Both rates come from a prescaler counter that clears on reset and then counts every clock. The 2'b01 strobe fires when the low 3 bits are all ones, and the 2'b10 strobe fires when the 5-bit count is 31.
- R4: `samp_sel_i` = 2'b11 samples only in cycles where `cnt_stb_i` is high.
- R5: The filtered level changes only when the last three samples are all 1 or all 0. Otherwise it holds its previous value.
- R6: `settled_o` is low in the clock after any change of `samp_sel_i`. It rises once two sample strobes have occurred since that change.
- R7: Reset (active-low `rst_n`, asynchronous) clears the synchronizer, the sample history, the filtered level, the prescaler and `settled_o` to 0.
- R8: The sample history keeps shifting while the filter is disabled. Re-enabling immediately presents the level derived from that current history.
- R9: `cap_o` reflects a change of `filt_en_i` in the same cycle, combinationally, with no masking of the resulting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous capture pin |
| filt_en_i | input | 1 | 1 = filtered level on `cap_o`, 0 = synchronized pin |
| samp_sel_i | input | 2 | Sampling source: 00 every clock, 01 /8, 10 /32, 11 timer strobe |
| cnt_stb_i | input | 1 | Timer count-clock strobe, one clock wide |
| cap_o | output | 1 | Level presented to the capture logic |
| settled_o | output | 1 | Two sample strobes seen since the last select change |

## Verification
The pin is driven with single-clock glitches, two-sample pulses and long steady levels under each sampling code. This separates a correct three-sample vote from a two-sample vote or a missing hold. The divided codes get long runs so that a wrong prescaler phase or period shows up as a shifted output edge. The timer-strobe code uses irregular strobe spacing to prove that nothing else samples. Select changes at random moments exercise the settle flag, and enable toggles both at clock boundaries and mid-cycle show the history carrying on through bypass and the unmasked switch edge.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  typedef enum logic [1:0] {
    SEL_EVERY = 2'b00,
    SEL_DIV_A = 2'b01,
    SEL_DIV_B = 2'b10,
    SEL_TIMER = 2'b11
  } samp_sel_e;
endpackage

// File: rtl/cdg_sync.sv
module cdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cdg_strobe.sv
module cdg_strobe
  import cdg_pkg::*;
#(
  parameter int DIV_A = 8,
  parameter int DIV_B = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       timer_stb_i,
  output logic       stb_o
);
  localparam int CW = $clog2(DIV_B);
  localparam int AW = $clog2(DIV_A);

  logic [CW-1:0] pre_q;
  logic          hit_a, hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  assign hit_a = &pre_q[AW-1:0];
  assign hit_b = &pre_q;

  always_comb begin
    unique case (samp_sel_e'(sel_i))
      SEL_EVERY: stb_o = 1'b1;
      SEL_DIV_A: stb_o = hit_a;
      SEL_DIV_B: stb_o = hit_b;
      SEL_TIMER: stb_o = timer_stb_i;
      default:   stb_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdg_vote.sv
module cdg_vote #(
  parameter int VOTES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             lvl_i,
  output logic [VOTES-1:0] hist_o,
  output logic             filt_o
);
  logic [VOTES-1:0] hist_q;
  logic             filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      if (stb_i) hist_q <= {hist_q[VOTES-2:0], lvl_i};
      if (&hist_q)       filt_q <= 1'b1;
      else if (~|hist_q) filt_q <= 1'b0;
    end
  end

  assign hist_o = hist_q;
  assign filt_o = filt_q;
endmodule

// File: rtl/capture_deglitch.sv
module capture_deglitch #(
  parameter int DIV_A          = 8,
  parameter int DIV_B          = 32,
  parameter int VOTES          = 3,
  parameter int SYNC_STAGES    = 2,
  parameter int SETTLE_STROBES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       filt_en_i,
  input  logic [1:0] samp_sel_i,
  input  logic       cnt_stb_i,
  output logic       cap_o,
  output logic       settled_o
);
  localparam int SW = $clog2(SETTLE_STROBES + 1);

  logic             pin_sync;
  logic             samp_stb;
  logic [VOTES-1:0] hist_q;
  logic             filt_q;
  logic [1:0]       sel_q;
  logic [SW-1:0]    settle_q;

  cdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cdg_strobe #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_stb (
    .clk(clk), .rst_n(rst_n), .sel_i(samp_sel_i),
    .timer_stb_i(cnt_stb_i), .stb_o(samp_stb)
  );

  cdg_vote #(.VOTES(VOTES)) u_vote (
    .clk(clk), .rst_n(rst_n), .stb_i(samp_stb), .lvl_i(pin_sync),
    .hist_o(hist_q), .filt_o(filt_q)
  );

  // settle tracking: restart on any select change, count strobes to a limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 2'b00;
      settle_q <= '0;
    end else begin
      sel_q <= samp_sel_i;
      if (samp_sel_i != sel_q)
        settle_q <= '0;
      else if (samp_stb && (settle_q != SW'(SETTLE_STROBES)))
        settle_q <= settle_q + 1'b1;
    end
  end

  assign settled_o = (settle_q == SW'(SETTLE_STROBES));
  // plain switch: the enable edge is passed on unmasked
  assign cap_o     = filt_en_i ? filt_q : pin_sync;
endmodule

// File: rtl/cdg_chk.sv
module cdg_chk #(
  parameter int VOTES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_i,
  input logic             filt_en_i,
  input logic [1:0]       samp_sel_i,
  input logic             cap_o,
  input logic             settled_o,
  input logic             samp_stb,
  input logic [VOTES-1:0] hist_q,
  input logic             filt_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  // R1
  bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en_i && age_q >= 2'd2) |-> (cap_o == $past(pin_i, 2)));

  // R5
  vote_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&hist_q) && (|hist_q)) |=> $stable(filt_q));

  // R6
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(samp_sel_i) |=> !settled_o);

  // R6
  settle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled_o) |-> $past(samp_stb));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!filt_q && !settled_o && hist_q == '0));
endmodule

bind capture_deglitch cdg_chk #(.VOTES(VOTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .filt_en_i(filt_en_i),
  .samp_sel_i(samp_sel_i), .cap_o(cap_o), .settled_o(settled_o),
  .samp_stb(samp_stb), .hist_q(hist_q), .filt_q(filt_q)
);

// File: tb/capture_deglitch_tb_top.sv
module capture_deglitch_tb_top;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, en = 1'b0, cstb = 1'b0;
  logic [1:0] sel = 2'b00;
  logic cap, settled;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R7";

  always #2.5 clk = ~clk;

  capture_deglitch dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .filt_en_i(en),
    .samp_sel_i(sel), .cnt_stb_i(cstb), .cap_o(cap), .settled_o(settled)
  );

  // behavioural reference
  int m_s1, m_s2, m_pc, m_f, m_cnt, m_selq;
  int hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pc = 0; m_f = 0; m_cnt = 0; m_selq = 0;
      hist = '{0, 0, 0};
    end else begin
      bit stb;
      int nf;
      case (sel)
        2'b00: stb = 1;
        2'b01: stb = (m_pc % 8) == 7;
        2'b10: stb = m_pc == 31;
        default: stb = cstb;
      endcase
      if (int'(sel) != m_selq) m_cnt = 0;
      else if (stb && m_cnt < 2) m_cnt++;
      m_selq = int'(sel);
      nf = m_f;
      if (hist[0] == 1 && hist[1] == 1 && hist[2] == 1) nf = 1;
      if (hist[0] == 0 && hist[1] == 0 && hist[2] == 0) nf = 0;
      if (stb) begin
        void'(hist.pop_front());
        hist.push_back(m_s2);
      end
      m_f = nf;
      m_s2 = m_s1;
      m_s1 = int'(pin);
      m_pc = (m_pc + 1) % 32;
    end
  end

  function automatic int exp_cap();
    return en ? m_f : m_s2;
  endfunction

  task automatic compare();
    checks++;
    if (int'(cap) != exp_cap()) begin
      errors++;
      $display("FAIL %s cap_o=%0d expected %0d at %0t", tag, cap, exp_cap(), $time);
    end
    checks++;
    if (int'(settled) != (m_cnt == 2 ? 1 : 0)) begin
      errors++;
      $display("FAIL %s settled_o=%0d expected %0d at %0t", tag, settled, m_cnt == 2, $time);
    end
  endtask

  // hold pin at a level for n cycles, comparing each cycle
  task automatic drive(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      pin = lvl;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired (tag %s) actual running expected finished", tag);
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    tag = "R7";
    checks++;
    if (cap !== 1'b0 || settled !== 1'b0) begin
      errors++;
      $display("FAIL R7 cap_o=%0b settled_o=%0b expected 0 0", cap, settled);
    end
    rst_n = 1'b1;

    // R1: bypass follows synchronized pin
    tag = "R1"; en = 0;
    for (int i = 0; i < 60; i++) drive(1'($urandom_range(0, 1)), 1);

    // R2 and R5: every-clock sampling, pulses of 1..5 and glitches
    tag = "R2"; en = 1; sel = 2'b00;
    drive(0, 8);
    for (int w = 1; w <= 5; w++) begin drive(1, w); drive(0, 8); end
    drive(1, 10);
    tag = "R5";
    for (int w = 1; w <= 3; w++) begin drive(0, w); drive(1, 6); end
    drive(0, 2); drive(1, 1); drive(0, 2); drive(1, 2); drive(0, 10);

    // R3: divided rates, long levels and short glitches
    tag = "R3"; sel = 2'b01;
    for (int k = 0; k < 12; k++) begin drive(1, 20 + k); drive(0, 3); drive(1, 5); drive(0, 30); end
    sel = 2'b10;
    for (int k = 0; k < 6; k++) begin drive(1, 100 + 3 * k); drive(0, 20); drive(1, 40); drive(0, 110); end

    // R4: timer strobe with irregular spacing
    tag = "R4"; sel = 2'b11;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      compare();
      cstb = ($urandom_range(0, 4) == 0);
      if ((i % 23) == 0) pin = ~pin;
    end
    cstb = 0;

    // R6: select changes at random moments
    tag = "R6";
    for (int k = 0; k < 30; k++) begin
      sel = 2'($urandom_range(0, 3));
      for (int i = 0; i < int'($urandom_range(1, 80)); i++) begin
        @(negedge clk);
        compare();
        cstb = ($urandom_range(0, 2) == 0);
        pin = ($urandom_range(0, 9) == 0) ? ~pin : pin;
      end
    end
    cstb = 0;

    // R8: history keeps moving during bypass
    tag = "R8"; sel = 2'b00; en = 1;
    drive(0, 10);
    en = 0;
    drive(1, 8);
    @(negedge clk);
    compare();
    en = 1;
    #0.5;
    checks++;
    if (cap !== 1'b1) begin
      errors++;
      $display("FAIL R8 cap_o=%0b expected 1 after re-enable", cap);
    end
    drive(1, 4);

    // R9: mid-cycle enable toggle shows at once
    tag = "R9";
    en = 1; drive(0, 2);
    @(negedge clk);
    compare();
    #0.5;
    en = 0;
    #0.5;
    checks++;
    if (cap !== 1'b0 || int'(cap) != exp_cap()) begin
      errors++;
      $display("FAIL R9 cap_o=%0b expected %0d right after enable drop", cap, exp_cap());
    end
    en = 1;
    #0.5;
    checks++;
    if (cap !== 1'b1) begin
      errors++;
      $display("FAIL R9 cap_o=%0b expected 1 right after enable rise", cap);
    end
    drive(0, 10);

    finish_run();
  end
endmodule